// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Controller

This block gathers single-cycle event pulses from up to sixteen DMA channel engines and turns them into latched, maskable status. It presents that status on a simple register port and drives one level-sensitive interrupt line. Each channel can raise four kinds of event:

- a completion at the end of its whole descriptor chain,
- a completion at the end of a node that was flagged for notification,
- two independent error kinds.

Each kind has its own latched (raw) word, its own enable word, and a masked word that is the AND of the two. The masked words of all four kinds are ORed per channel into one combined status word. Software reads the combined word, services the channels it flags, and clears the latched events by writing ones to the raw words.

The block also shows the live busy flags of the channels and holds a channel priority word for the engines. The register port is plain and single-cycle, with no handshake:

- A write takes effect at the clock edge where `reg_we` is high.
- Read data follows `reg_addr` combinationally in the same cycle.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Registers sit at fixed byte offsets:

  | Offset | Register |
  |---|---|
  | 0x000 | combined status |
  | 0x004, 0x008, 0x00C, 0x010 | masked chain, node, error-A, error-B |
  | 0x018, 0x01C, 0x020, 0x024 | enables for the same four kinds, in the same order |
  | 0x600, 0x608, 0x610, 0x618 | raw for the same four kinds, in the same order |
  | 0x688 | priority |
  | 0x690 | busy |

  Any other offset reads zero. In every per-channel word, bit i belongs to channel i, and bits at or above the channel count read zero.
- R2: An event pulse on channel i of a kind sets raw bit i of that kind at the next clock edge. The bit then stays set until software clears it.
- R3: A write to a raw register clears every raw bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: When an event pulse and a write-1 clear hit the same raw bit at the same edge, the bit ends up set.
- R5: A masked word reads as its raw word ANDed with its enable word. An enable bit of 1 passes the event. Enable words are written directly and read back.
- R6: Combined status bit i is the OR of channel i's four masked bits.
- R7: `irq` is high exactly while any combined status bit is set. It is a level, not a pulse, and it falls in the cycle after the last enabled pending bit is cleared or disabled.
- R8: The busy register reads back the current `ch_busy` input with no delay.
- R9: The priority register holds the last 32-bit value written to it and drives it on `chan_prio`. The value 0 means all channels have equal rank.
- R10: After reset, every raw, enable, priority and status value is zero and `irq` is low.
- R11: Writes to the combined, masked and busy offsets, and to unmapped offsets, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_chain_done | input | NUM_CH | One pulse per channel at the end of its descriptor chain |
| evt_node_done | input | NUM_CH | One pulse per channel at the end of a flagged node |
| evt_err_a | input | NUM_CH | First error kind, one pulse per channel |
| evt_err_b | input | NUM_CH | Second error kind, one pulse per channel |
| ch_busy | input | NUM_CH | Live running flag of each channel |
| reg_we | input | 1 | Write strobe; the write lands at this clock edge |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| chan_prio | output | DATA_W | Stored priority word |
| irq | output | 1 | Level interrupt, high while any enabled event is pending |

## Verification
The bench aims at four corner cases:

- **A clear that coincides with a new event on the same bit.** A design that lets the clear win would silently lose an interrupt.
- **Partial clears and partial enables.** A design that clears whole words or ignores the enables would show wrong masked words and a stuck or missing `irq`.
- **Writes aimed at read-only and unmapped offsets.** A sloppy decoder would alias these onto a raw or enable word and change it.
- **The timing of `irq` after the final clear.** A registered or pulse-shaped output would be one cycle off, or would drop while events are still pending.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int NUM_CLS = 4;

  // event kinds; index order sets the offset order of each register group
  typedef enum logic [1:0] {
    CLS_CHAIN = 2'd0,
    CLS_NODE  = 2'd1,
    CLS_ERR_A = 2'd2,
    CLS_ERR_B = 2'd3
  } evt_cls_e;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PRIO   = 12'h688;
  localparam logic [ADDR_W-1:0] OFS_BUSY   = 12'h690;

  function automatic logic [ADDR_W-1:0] ofs_masked(input int k);
    return ADDR_W'(12'h004 + 4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] ofs_enable(input int k);
    return ADDR_W'(12'h018 + 4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] ofs_raw(input int k);
    return ADDR_W'(12'h600 + 8 * k);
  endfunction
endpackage

// File: rtl/dmairq_class.sv
module dmairq_class #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] en_bits,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] raw_q, en_q, clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      // a pulse arriving with the clear keeps the bit set
      raw_q <= (raw_q & ~clr_eff) | evt;
      if (en_we) en_q <= en_bits;
    end
  end

  assign raw_o  = raw_q;
  assign en_o   = en_q;
  assign pend_o = raw_q & en_q;

  assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(raw_q) & ~raw_q & ~$past(clr_eff)) == '0));

  assert_no_spur_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(evt)) == '0));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_q & $past(clr_bits & ~evt)) == '0));

  assert_enable_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(en_bits)));
endmodule

// File: rtl/dmairq_regif.sv
module dmairq_regif
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]  raw,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]  en,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]  pend,
  input  logic [NUM_CH-1:0]               status,
  input  logic [NUM_CH-1:0]               busy,
  input  logic [DATA_W-1:0]               prio,
  output logic [NUM_CLS-1:0]              clr_we,
  output logic [NUM_CLS-1:0]              en_we,
  output logic                            prio_we,
  output logic [DATA_W-1:0]               reg_rdata
);
  // write decode: only raw, enable and priority words are writable
  always_comb begin
    for (int k = 0; k < NUM_CLS; k++) begin
      clr_we[k] = reg_we && (reg_addr == ofs_raw(k));
      en_we[k]  = reg_we && (reg_addr == ofs_enable(k));
    end
    prio_we = reg_we && (reg_addr == OFS_PRIO);
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_STATUS) reg_rdata[NUM_CH-1:0] = status;
    if (reg_addr == OFS_BUSY)   reg_rdata[NUM_CH-1:0] = busy;
    if (reg_addr == OFS_PRIO)   reg_rdata = prio;
    for (int k = 0; k < NUM_CLS; k++) begin
      if (reg_addr == ofs_masked(k)) reg_rdata[NUM_CH-1:0] = pend[k];
      if (reg_addr == ofs_enable(k)) reg_rdata[NUM_CH-1:0] = en[k];
      if (reg_addr == ofs_raw(k))    reg_rdata[NUM_CH-1:0] = raw[k];
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_chain_done,
  input  logic [NUM_CH-1:0] evt_node_done,
  input  logic [NUM_CH-1:0] evt_err_a,
  input  logic [NUM_CH-1:0] evt_err_b,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] chan_prio,
  output logic              irq
);
  logic [NUM_CLS-1:0][NUM_CH-1:0] evt_all, raw, en, pend;
  logic [NUM_CLS-1:0]             clr_we, en_we;
  logic                           prio_we;
  logic [NUM_CH-1:0]              status;
  logic [DATA_W-1:0]              prio_q;

  assign evt_all = {evt_err_b, evt_err_a, evt_node_done, evt_chain_done};

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    dmairq_class #(.NUM_CH(NUM_CH)) u_cls (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_all[k]),
      .clr_we   (clr_we[k]),
      .clr_bits (reg_wdata[NUM_CH-1:0]),
      .en_we    (en_we[k]),
      .en_bits  (reg_wdata[NUM_CH-1:0]),
      .raw_o    (raw[k]),
      .en_o     (en[k]),
      .pend_o   (pend[k])
    );
  end

  always_comb begin
    status = '0;
    for (int k = 0; k < NUM_CLS; k++) status |= pend[k];
  end

  assign irq = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= '0;
    else if (prio_we) prio_q <= reg_wdata;
  end
  assign chan_prio = prio_q;

  dmairq_regif #(.NUM_CH(NUM_CH)) u_regif (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .raw       (raw),
    .en        (en),
    .pend      (pend),
    .status    (status),
    .busy      (ch_busy),
    .prio      (prio_q),
    .clr_we    (clr_we),
    .en_we     (en_we),
    .prio_we   (prio_we),
    .reg_rdata (reg_rdata)
  );

  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw & en)));

  assert_prio_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_PRIO) |=> (chan_prio == $past(reg_wdata)));

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_we, en_we, prio_we}));
endmodule

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ev [4];
  logic [N-1:0] busy;
  logic we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata, prio;
  logic irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit ro_wr_prev = 0;

  // behavioural model state
  logic [N-1:0] m_raw [4];
  logic [N-1:0] m_en [4];
  logic [31:0] m_prio;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .evt_chain_done(ev[0]), .evt_node_done(ev[1]),
    .evt_err_a(ev[2]), .evt_err_b(ev[3]),
    .ch_busy(busy), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .chan_prio(prio), .irq(irq));

  logic [11:0] rd_list [17] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
    12'h018, 12'h01C, 12'h020, 12'h024, 12'h600, 12'h608, 12'h610, 12'h618,
    12'h688, 12'h690, 12'h014, 12'h604};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin m_raw[k] = '0; m_en[k] = '0; end
      m_prio = '0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (we && addr == 12'h600 + 12'(8*k)) m_raw[k] = m_raw[k] & ~wdata[N-1:0];
        m_raw[k] = m_raw[k] | ev[k];
        if (we && addr == 12'h018 + 12'(4*k)) m_en[k] = wdata[N-1:0];
      end
      if (we && addr == 12'h688) m_prio = wdata;
    end
  end

  function automatic logic [N-1:0] m_status();
    logic [N-1:0] s = '0;
    for (int k = 0; k < 4; k++) s |= m_raw[k] & m_en[k];
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h000) r[N-1:0] = m_status();
    if (a == 12'h688) r = m_prio;
    if (a == 12'h690) r[N-1:0] = busy;
    for (int k = 0; k < 4; k++) begin
      if (a == 12'h004 + 12'(4*k)) r[N-1:0] = m_raw[k] & m_en[k];
      if (a == 12'h018 + 12'(4*k)) r[N-1:0] = m_en[k];
      if (a == 12'h600 + 12'(8*k)) r[N-1:0] = m_raw[k];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (!rst_n) return "R10";
    if (ro_wr_prev) return "R11";
    if (a == 12'h000) return "R6";
    if (a >= 12'h004 && a <= 12'h024 && a != 12'h014) return "R5";
    if (a >= 12'h600 && a <= 12'h618 && a[2:0] == 3'd0) return "R2/R3/R4";
    if (a == 12'h688) return "R9";
    if (a == 12'h690) return "R8";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", req, addr, act, exp, $time);
    end
  endtask

  // compare, then drive the next cycle's inputs
  task automatic step(input bit w, input logic [11:0] a, input logic [31:0] d,
                      input logic [N-1:0] e0, input logic [N-1:0] e1,
                      input logic [N-1:0] e2, input logic [N-1:0] e3);
    @(negedge clk);
    cyc++;
    check(tag_of(addr), rdata, m_read(addr));
    check(rst_n ? "R7" : "R10", {31'd0, irq}, {31'd0, |m_status()});
    check("R9", prio, m_prio);
    ro_wr_prev = we && (addr == 12'h000 || addr == 12'h004 || addr == 12'h690 || addr == 12'h014);
    we = w; addr = a; wdata = d;
    ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
    busy = N'($urandom);
  endtask

  function automatic logic [N-1:0] sparse();
    return N'($urandom & $urandom & $urandom);
  endfunction

  initial begin
    we = 0; addr = '0; wdata = '0; busy = '0;
    for (int k = 0; k < 4; k++) ev[k] = '0;
    // R10: reset state read across the map
    for (int i = 0; i < 17; i++) step(0, rd_list[i], 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 17; i++) step(0, rd_list[i], 0, 0, 0, 0, 0);
    // R5: enable all kinds
    for (int k = 0; k < 4; k++) step(1, 12'h018 + 12'(4*k), 32'hFFFF, 0, 0, 0, 0);
    // R2 / R3: events, then partial clears
    for (int i = 0; i < 80; i++) begin
      if (i % 5 == 4) step(1, 12'h600 + 12'(8*(i%4)), $urandom, sparse(), sparse(), 0, 0);
      else step(0, rd_list[i%17], 0, sparse(), sparse(), sparse(), sparse());
    end
    // R4: pulse and clear on the same bit in the same cycle
    step(1, 12'h600, 32'hFFFF, 16'h0008, 0, 0, 0);
    step(0, 12'h600, 0, 0, 0, 0, 0);
    step(0, 12'h000, 0, 0, 0, 0, 0);
    // R11: writes to read-only and unmapped offsets
    step(1, 12'h000, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 12'h004, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 12'h690, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 12'h014, 32'hFFFF_FFFF, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) step(0, rd_list[i], 0, 0, 0, 0, 0);
    // R9: priority word
    step(1, 12'h688, 32'hA5A5_0F0F, 0, 0, 0, 0);
    step(1, 12'h688, 32'h0, 0, 0, 0, 0);
    step(1, 12'h688, 32'h1234_5678, 0, 0, 0, 0);
    // mixed traffic with partial enables
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) == 0, rd_list[$urandom % 17], $urandom,
           sparse(), sparse(), sparse(), sparse());
    // R7: clear all raw, then check irq falls; then disable enables with pending bits
    for (int k = 0; k < 4; k++) step(1, 12'h600 + 12'(8*k), 32'hFFFF, 0, 0, 0, 0);
    step(0, 12'h000, 0, 0, 0, 0, 0);
    step(0, 12'h000, 0, 16'hFFFF, 16'h00F0, 0, 0);
    for (int k = 0; k < 4; k++) step(1, 12'h018 + 12'(4*k), 32'h0, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) step(0, rd_list[i], 0, 0, 0, 0, 0);
    finish_run();
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule